// File: doc/BRIEF.md
# Consistent-Read Window Interrupt Generator

This block watches the status lines of a periodic servo update engine. It raises an interrupt while the host can safely read a group of related RAM values, because the engine is not rewriting any of them in that span. A window is safe when the engine is running and none of its update units reports busy. To reject short gaps between updates, this condition must hold for a set number of consecutive cycles before a window is declared open.

The interrupt sets once, at the opening edge of each window. The host can drop it early with a one-cycle clear pulse. After such a pulse it stays low until the next window opens. If the host never clears it, the interrupt falls by itself when the window closes, and a sticky flag then records that a window went unserviced.

The controller has three states. `ST_IDLE` means no window is open. `ST_PEND` means a window is open and the interrupt is raised. `ST_ACKED` means a window is open and the host has cleared the interrupt. The transitions are:

- `T_OPEN`: a window opens, so IDLE goes to PEND. This happens even when a clear pulse arrives in the same cycle.
- `T_ACK`: the host clears the interrupt, so PEND goes to ACKED.
- `T_EXPIRE`: the window closes while the interrupt is still pending, so PEND goes to IDLE and the missed flag is set. This happens unless a clear pulse arrives in the same cycle.
- `T_CLOSE`: the window closes after the host has cleared the interrupt, so ACKED goes to IDLE.

Top module: `win_irq_gen`

## Requirements
- R1: After reset, `irq`, `safe_now` and `win_missed` are all 0.
- R2: The raw safe condition is `eng_run` = 1 with every bit of `eng_busy` = 0, where bit i = 1 means update unit i is writing. `safe_now` becomes 1 at the SETTLE-th rising edge during which the raw condition holds without a break.
- R3: When the raw condition fails, because `eng_run` = 0 or any busy bit = 1, `safe_now` is 0 after the next rising edge.
- R4: `irq` rises one clock after `safe_now` rises.
- R5: A 1 on `irq_clr` while `irq` is 1 makes `irq` 0 after the next edge. `irq` then stays 0 for the rest of that window.
- R6: `irq_clr` has no effect when `irq` is 0. Pulses outside a window, or after a clear inside a window, leave `irq` low and do not stop the next window from raising it.
- R7: If the host does not clear it, `irq` falls one clock after `safe_now` falls.
- R8: A clear pulse in the same cycle as a window opening, that is the first cycle with `safe_now` = 1, loses to the set, so `irq` still rises.
- R9: `win_missed` becomes 1 when a window closes while `irq` is still pending and no clear arrives in that cycle. It then stays 1 until reset. A window that was cleared before it closed, or in the cycle it closed, does not set it.
- R10: A raw safe spell shorter than SETTLE cycles produces neither `safe_now` nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_run | input | 1 | Servo engine running |
| eng_busy | input | NUM_ENG | Per-unit update-in-progress flags |
| irq_clr | input | 1 | Host clear pulse for the interrupt |
| irq | output | 1 | Interrupt request: safe to read |
| safe_now | output | 1 | Qualified safe-read condition |
| win_missed | output | 1 | Sticky: a window closed unserviced |

## Verification
A host clear and a window edge can land in the same cycle, and the bench provokes both cases. In the first, the clear pulse is driven exactly in the first cycle that `safe_now` reads 1. The interrupt must still rise on the next edge. In the second, the clear pulse is driven in the first cycle after `safe_now` drops while the interrupt is pending. The interrupt must fall, and `win_missed` must stay 0. This is confirmed before a deliberately unserviced window shows the flag setting.

// File: rtl/win_irq_pkg.sv
package win_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_ACKED = 2'd2
    } win_state_e;

endpackage

// File: rtl/win_qualify.sv
module win_qualify #(
    parameter int NUM_ENG = 4,
    parameter int SETTLE  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eng_run,
    input  logic [NUM_ENG-1:0] eng_busy,
    output logic               safe_q,
    output logic               win_open
);

    logic raw_safe;
    logic safe_d;

    assign raw_safe = eng_run && (eng_busy == '0);

    generate
        if (SETTLE <= 1) begin : g_direct
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    safe_q <= 1'b0;
                end else begin
                    safe_q <= raw_safe;
                end
            end
        end else begin : g_settle
            localparam int CW = $clog2(SETTLE);
            localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);
            logic [CW-1:0] run_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    run_cnt <= '0;
                    safe_q  <= 1'b0;
                end else if (!raw_safe) begin
                    run_cnt <= '0;
                    safe_q  <= 1'b0;
                end else if (run_cnt == LAST) begin
                    safe_q  <= 1'b1;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            safe_d <= 1'b0;
        end else begin
            safe_d <= safe_q;
        end
    end

    assign win_open = safe_q && !safe_d;

endmodule

// File: rtl/win_irq_fsm.sv
module win_irq_fsm
    import win_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_open,
    input  logic safe,
    input  logic clr,
    output logic irq,
    output logic missed
);

    win_state_e state_q;
    win_state_e state_n;
    logic       miss_set;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n  = state_q;
        miss_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_open) begin
                    state_n = ST_PEND;          // T_OPEN, set beats clear
                end
            end
            ST_PEND: begin
                if (!safe) begin
                    state_n  = ST_IDLE;         // T_EXPIRE
                    miss_set = !clr;
                end else if (clr) begin
                    state_n = ST_ACKED;         // T_ACK
                end
            end
            ST_ACKED: begin
                if (!safe) begin
                    state_n = ST_IDLE;          // T_CLOSE
                end
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            missed <= 1'b0;
        end else if (miss_set) begin
            missed <= 1'b1;
        end
    end

    assign irq = (state_q == ST_PEND);

endmodule

// File: rtl/win_irq_gen.sv
module win_irq_gen #(
    parameter int NUM_ENG = 4,
    parameter int SETTLE  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eng_run,
    input  logic [NUM_ENG-1:0] eng_busy,
    input  logic               irq_clr,
    output logic               irq,
    output logic               safe_now,
    output logic               win_missed
);

    logic safe_q;
    logic win_open;

    win_qualify #(
        .NUM_ENG(NUM_ENG),
        .SETTLE (SETTLE)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .eng_run (eng_run),
        .eng_busy(eng_busy),
        .safe_q  (safe_q),
        .win_open(win_open)
    );

    win_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_open(win_open),
        .safe    (safe_q),
        .clr     (irq_clr),
        .irq     (irq),
        .missed  (win_missed)
    );

    assign safe_now = safe_q;

endmodule

// File: rtl/win_irq_gen_chk.sv
module win_irq_gen_chk #(
    parameter int NUM_ENG = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               eng_run,
    input logic [NUM_ENG-1:0] eng_busy,
    input logic               irq_clr,
    input logic               irq,
    input logic               safe_now,
    input logic               win_missed
);

    // R2
    safe_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(safe_now) |-> $past(eng_run && (eng_busy == '0)));

    // R3
    safe_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_run && (eng_busy == '0)) |=> !safe_now);

    // R4
    irq_follows_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_now && !$past(safe_now)) |=> irq);

    // R4
    irq_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(safe_now));

    // R5
    clr_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_clr) |=> !irq);

    // R6
    no_reset_midwindow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && safe_now && $past(safe_now)) |=> !irq);

    // R7
    auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !safe_now |=> !irq);

    // R9
    missed_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_missed) |-> $past(irq && !irq_clr));

    // R9
    missed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_missed |=> win_missed);

endmodule

bind win_irq_gen win_irq_gen_chk #(.NUM_ENG(NUM_ENG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_run   (eng_run),
    .eng_busy  (eng_busy),
    .irq_clr   (irq_clr),
    .irq       (irq),
    .safe_now  (safe_now),
    .win_missed(win_missed)
);

// File: tb/win_irq_gen_tb.sv
module win_irq_gen_tb;

    localparam int NUM_ENG = 4;
    localparam int SETTLE  = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               eng_run = 1'b0;
    logic [NUM_ENG-1:0] eng_busy = '1;
    logic               irq_clr = 1'b0;
    logic               irq;
    logic               safe_now;
    logic               win_missed;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    win_irq_gen #(.NUM_ENG(NUM_ENG), .SETTLE(SETTLE)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_run   (eng_run),
        .eng_busy  (eng_busy),
        .irq_clr   (irq_clr),
        .irq       (irq),
        .safe_now  (safe_now),
        .win_missed(win_missed)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic go_safe();
        eng_run  = 1'b1;
        eng_busy = '0;
    endtask

    task automatic go_busy();
        eng_busy = 4'b0100;
    endtask

    // opens a window and lands one cycle after safe_now rises
    task automatic open_window();
        go_safe();
        step(SETTLE);
        chk("R2 safe_now after settle", safe_now, 1'b1);
        chk("R4 irq not yet", irq, 1'b0);
        step(1);
        chk("R4 irq raised", irq, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 irq", irq, 1'b0);
        chk("R1 safe_now", safe_now, 1'b0);
        chk("R1 win_missed", win_missed, 1'b0);
    endtask

    task automatic t_sw_clear();
        go_safe();
        step(SETTLE - 1);
        chk("R2 safe_now early", safe_now, 1'b0);
        step(1);
        chk("R2 safe_now", safe_now, 1'b1);
        step(1);
        chk("R4 irq", irq, 1'b1);
        step(3);
        chk("R4 irq held", irq, 1'b1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        chk("R5 cleared", irq, 1'b0);
        step(4);
        chk("R5 stays low in window", irq, 1'b0);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        chk("R6 clear while low", irq, 1'b0);
        go_busy();
        step(1);
        chk("R3 safe_now drops", safe_now, 1'b0);
        step(2);
        chk("R9 no miss after clear", win_missed, 1'b0);
    endtask

    task automatic t_short_spell();
        eng_run = 1'b0;
        eng_busy = '0;
        step(2);
        eng_run = 1'b1;
        step(SETTLE - 1);
        eng_run = 1'b0;
        step(1);
        chk("R10 no safe_now", safe_now, 1'b0);
        step(2);
        chk("R10 no irq", irq, 1'b0);
        chk("R3 run low keeps off", safe_now, 1'b0);
    endtask

    task automatic t_open_collision();
        go_safe();
        step(SETTLE);
        chk("R8 first safe cycle", safe_now, 1'b1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        chk("R8 set beats clear", irq, 1'b1);
    endtask

    task automatic t_close_collision();
        go_busy();
        step(1);
        chk("R3 window closed", safe_now, 1'b0);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        chk("R7 irq low", irq, 1'b0);
        chk("R9 clear at close no miss", win_missed, 1'b0);
    endtask

    task automatic t_idle_clear();
        step(2);
        irq_clr = 1'b1;
        step(2);
        irq_clr = 1'b0;
        chk("R6 idle clear irq", irq, 1'b0);
        open_window();
        chk("R6 next window unaffected", irq, 1'b1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        go_busy();
        step(3);
    endtask

    task automatic t_auto_clear();
        open_window();
        step(2);
        go_busy();
        step(1);
        chk("R3 safe_now low", safe_now, 1'b0);
        chk("R7 irq still up", irq, 1'b1);
        chk("R9 not yet", win_missed, 1'b0);
        step(1);
        chk("R7 auto cleared", irq, 1'b0);
        chk("R9 missed set", win_missed, 1'b1);
        open_window();
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        go_busy();
        step(3);
        chk("R9 sticky", win_missed, 1'b1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        go_busy();
        step(1);
        t_sw_clear();
        t_short_spell();
        t_open_collision();
        t_close_collision();
        t_idle_clear();
        t_auto_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule